// File: doc/BRIEF.md
# Serial Receive Holding Register with Error Status

This block sits between a serial receiver core and the bus. It keeps the most recent received character (up to nine data bits) and a set of sticky status flags: parity error, framing error, overrun and arbitration lost. A summary bit reports whether any of the three receive errors is present. The bus reads everything through one 16-bit view. A strobe marks a read of the lower byte, and a one-bit write path reaches the arbitration-lost flag.

Each flag has its own clearing rule. Reading the lower byte clears the parity and framing flags and marks the character as consumed. Overrun is cleared only when reception is disabled. Disabling reception, either by setting the mode field to zero or by dropping the receive enable, clears all receive error flags. The arbitration-lost flag is cleared only by a software write of zero. A build parameter removes the arbitration-lost flag entirely.

Top module: `rxbuf_status_reg`

## Requirements
- R1: The read view carries the last captured character in bits 8:0. Bits 10:9 always read 0.
- R2: After a synchronous reset the whole read view is 0.
- R3: Bit 15 (error summary) is 1 exactly when at least one of bit 14 (parity), bit 13 (framing) or bit 12 (overrun) is 1.
- R4: A lower-byte read strobe clears the parity and framing flags. It leaves overrun, arbitration-lost and the data unchanged.
- R5: Reception is disabled while `mode_sel` is 3'b000 or `rx_enable` is 0. While it is disabled, the parity, framing, overrun and summary bits are cleared, a receive strobe is ignored (the data holds), and the arbitration-lost flag is unaffected.
- R6: The arbitration-lost flag (bit 11) is set by an `arb_lost` pulse. It is cleared only when `wr_en` is high and `wr_arb_val` is 0. A write of 1 leaves the flag unchanged.
- R7: With `ARB_EN` = 0, bit 11 reads 0 at all times, whatever `arb_lost` does.
- R8: A receive strobe that arrives while the previous character is unread sets the overrun flag, and the new character replaces the old one. If a lower-byte read happens in the same cycle as the strobe, no overrun is flagged.
- R9: A new flag-set event wins over a same-cycle clear. This holds for parity and framing against a read, and for arbitration-lost against a write of 0.
- R10: The parity and framing inputs are sampled only in a cycle where `rx_done` is high. At any other time they have no effect.
- R11: The overrun flag survives lower-byte reads and stays set until reception is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Serial mode field; 3'b000 means serial disabled |
| rx_enable | input | 1 | Receive enable |
| rx_done | input | 1 | One-cycle strobe: a character has completed |
| rx_word | input | 9 | Received character, valid with `rx_done` |
| rx_par_err | input | 1 | Parity error for the character, valid with `rx_done` |
| rx_frm_err | input | 1 | Framing error for the character, valid with `rx_done` |
| arb_lost | input | 1 | One-cycle arbitration-lost event |
| rd_lo | input | 1 | Lower-byte read strobe |
| wr_en | input | 1 | Write strobe for the arbitration-lost flag |
| wr_arb_val | input | 1 | Value written to the arbitration-lost flag |
| rd_data | output | 16 | Read view of data and status |

## Verification
The bench walks all 512 character values, each combined with a parity/framing pattern, and checks that the flags are captured and then cleared by a read. A design that mispacked the view or cleared the wrong bits fails here. It also drives same-cycle collisions: a read together with a new error, a read together with a new character, and a write of zero together with an arbitration event. A design that let the clear win, or that flagged overrun on a character read in the same cycle, would report the wrong flags. Further cases check that overrun survives reads, that the receive strobe and the error inputs are ignored while reception is disabled, and that bit 11 stays at zero in the build without arbitration.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    localparam int DATA_W   = 9;
    localparam int VIEW_W   = 16;
    localparam int MODE_W   = 3;
    localparam int POS_ARB  = 11;
    localparam int POS_OVR  = 12;
    localparam int POS_FRM  = 13;
    localparam int POS_PAR  = 14;
    localparam int POS_SUM  = 15;
    localparam int PAD_W    = POS_ARB - DATA_W;

    localparam logic [MODE_W-1:0] MODE_OFF = '0;

    typedef struct packed {
        logic par;
        logic frm;
        logic ovr;
    } err_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } slot_t;

    function automatic logic rx_active(input logic [MODE_W-1:0] mode,
                                       input logic              en);
        return (mode != MODE_OFF) && en;
    endfunction

    function automatic logic [VIEW_W-1:0] pack_view(input logic [DATA_W-1:0] data,
                                                     input err_t              e,
                                                     input logic              sum,
                                                     input logic              arb);
        logic [VIEW_W-1:0] v;
        v                = '0;
        v[DATA_W-1:0]    = data;
        v[POS_ARB]       = arb;
        v[POS_OVR]       = e.ovr;
        v[POS_FRM]       = e.frm;
        v[POS_PAR]       = e.par;
        v[POS_SUM]       = sum;
        return v;
    endfunction

endpackage

// File: rtl/rxbuf_data_store.sv
module rxbuf_data_store
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rd_lo,
    output slot_t             slot,
    output logic              ovr_evt
);

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (!active) begin
            slot_q.full <= 1'b0;
        end else if (rx_done) begin
            slot_q.data <= rx_word;
            slot_q.full <= 1'b1;
        end else if (rd_lo) begin
            slot_q.full <= 1'b0;
        end
    end

    assign slot    = slot_q;
    assign ovr_evt = active && rx_done && slot_q.full && !rd_lo;

    AST_IDLE_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(active && rx_done) |=> $stable(slot_q.data)); // R5

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !rx_done) |=> !slot_q.full); // R8

endmodule

// File: rtl/rxbuf_err_flags.sv
module rxbuf_err_flags
    import rxbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  err_t set_evt,
    input  logic rd_lo,
    output err_t flags,
    output logic sum
);

    err_t flags_q;
    err_t flags_n;
    logic sum_q;

    always_comb begin
        if (!active) begin
            flags_n = '0;
        end else begin
            flags_n.par = set_evt.par | (flags_q.par & ~rd_lo);
            flags_n.frm = set_evt.frm | (flags_q.frm & ~rd_lo);
            flags_n.ovr = set_evt.ovr | flags_q.ovr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            sum_q   <= 1'b0;
        end else begin
            flags_q <= flags_n;
            sum_q   <= |flags_n;
        end
    end

    assign flags = flags_q;
    assign sum   = sum_q;

    AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (rst)
        sum_q == (flags_q.par | flags_q.frm | flags_q.ovr)); // R3

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !active |=> (flags_q == '0) && !sum_q); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !set_evt.par && !set_evt.frm) |=> !flags_q.par && !flags_q.frm); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (active && flags_q.ovr) |=> flags_q.ovr); // R11

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (active && set_evt.par) |=> flags_q.par); // R9

endmodule

// File: rtl/rxbuf_arb_flag.sv
module rxbuf_arb_flag #(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic arb_evt,
    input  logic wr_en,
    input  logic wr_val,
    output logic arb
);

    generate
        if (ENABLE) begin : g_arb
            logic arb_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    arb_q <= 1'b0;
                end else if (arb_evt) begin
                    arb_q <= 1'b1;
                end else if (wr_en && !wr_val) begin
                    arb_q <= 1'b0;
                end
            end

            assign arb = arb_q;

            AST_ONE_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_val && !arb_evt) |=> $stable(arb_q)); // R6

            AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
                arb_evt |=> arb_q); // R9
        end else begin : g_no_arb
            logic unused_arb_in;
            assign unused_arb_in = ^{clk, rst, arb_evt, wr_en, wr_val};
            assign arb = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rxbuf_status_reg.sv
module rxbuf_status_reg
    import rxbuf_pkg::*;
#(
    parameter bit ARB_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              rx_enable,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              arb_lost,
    input  logic              rd_lo,
    input  logic              wr_en,
    input  logic              wr_arb_val,
    output logic [VIEW_W-1:0] rd_data
);

    logic  active;
    slot_t slot;
    logic  ovr_evt;
    err_t  set_evt;
    err_t  flags;
    logic  sum;
    logic  arb;

    assign active = rx_active(mode_sel, rx_enable);

    rxbuf_data_store u_store (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .rx_done (rx_done),
        .rx_word (rx_word),
        .rd_lo   (rd_lo),
        .slot    (slot),
        .ovr_evt (ovr_evt)
    );

    always_comb begin
        set_evt.par = rx_done & rx_par_err;
        set_evt.frm = rx_done & rx_frm_err;
        set_evt.ovr = ovr_evt;
    end

    rxbuf_err_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .set_evt (set_evt),
        .rd_lo   (rd_lo),
        .flags   (flags),
        .sum     (sum)
    );

    rxbuf_arb_flag #(.ENABLE(ARB_EN)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .arb_evt (arb_lost),
        .wr_en   (wr_en),
        .wr_val  (wr_arb_val),
        .arb     (arb)
    );

    assign rd_data = pack_view(slot.data, flags, sum, arb);

    AST_OVERRUN_REPLACES: assert property (@(posedge clk) disable iff (rst)
        (active && rx_done && slot.full && !rd_lo)
        |=> rd_data[POS_OVR] && (rd_data[DATA_W-1:0] == $past(rx_word))); // R8

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[POS_ARB-1:DATA_W] == '0); // R1

    AST_NOARB_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ARB_EN |-> !rd_data[POS_ARB]); // R7

endmodule

// File: tb/rxbuf_status_reg_tb_top.sv
module rxbuf_status_reg_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_sel = 3'b000;
    logic        rx_enable = 1'b0;
    logic        rx_done = 1'b0;
    logic [8:0]  rx_word = '0;
    logic        rx_par_err = 1'b0;
    logic        rx_frm_err = 1'b0;
    logic        arb_lost = 1'b0;
    logic        rd_lo = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_arb_val = 1'b0;
    logic [15:0] rd_data;
    logic [15:0] rd_data_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxbuf_status_reg #(.ARB_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .rx_enable(rx_enable),
        .rx_done(rx_done), .rx_word(rx_word), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .arb_lost(arb_lost), .rd_lo(rd_lo),
        .wr_en(wr_en), .wr_arb_val(wr_arb_val), .rd_data(rd_data)
    );

    rxbuf_status_reg #(.ARB_EN(1'b0)) dut_noarb_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .rx_enable(rx_enable),
        .rx_done(rx_done), .rx_word(rx_word), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .arb_lost(arb_lost), .rd_lo(rd_lo),
        .wr_en(wr_en), .wr_arb_val(wr_arb_val), .rd_data(rd_data_n)
    );

    function automatic logic [15:0] exp_view(input logic [8:0] d, input logic par,
                                             input logic frm, input logic ovr,
                                             input logic arb);
        return {par | frm | ovr, par, frm, ovr, arb, 2'b00, d};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        rx_done  = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
        arb_lost = 1'b0; rd_lo = 1'b0; wr_en = 1'b0; wr_arb_val = 1'b0;
    endtask

    task automatic recv(input logic [8:0] d, input logic par, input logic frm);
        rx_done = 1'b1; rx_word = d; rx_par_err = par; rx_frm_err = frm;
    endtask

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        check("R2 reset view", rd_data, 16'h0000);
        mode_sel = 3'b001; rx_enable = 1'b1;

        // R1 R3 R10 R4: sweep over every character value
        for (int d = 0; d < 512; d++) begin
            logic [8:0] w;
            w = d[8:0];
            recv(w, w[0], w[1]);
            step();
            check("R1 R3 capture", rd_data, exp_view(w, w[0], w[1], 1'b0, 1'b0));
            rd_lo = 1'b1;
            step();
            check("R4 read clears", rd_data, exp_view(w, 1'b0, 1'b0, 1'b0, 1'b0));
        end

        // R10: error inputs without strobe
        rx_par_err = 1'b1; rx_frm_err = 1'b1;
        step();
        check("R10 no strobe", rd_data, exp_view(9'h1FF, 1'b0, 1'b0, 1'b0, 1'b0));

        // R8 overrun, R11 survives read
        recv(9'h055, 1'b0, 1'b0); step();
        check("R8 first char", rd_data, exp_view(9'h055, 1'b0, 1'b0, 1'b0, 1'b0));
        recv(9'h1AA, 1'b0, 1'b0); step();
        check("R8 overrun set", rd_data, exp_view(9'h1AA, 1'b0, 1'b0, 1'b1, 1'b0));
        rd_lo = 1'b1; step();
        check("R11 ovr after read", rd_data, exp_view(9'h1AA, 1'b0, 1'b0, 1'b1, 1'b0));

        // R5 disable by mode
        mode_sel = 3'b000; step();
        check("R5 mode off clears", rd_data, exp_view(9'h1AA, 1'b0, 1'b0, 1'b0, 1'b0));
        recv(9'h0FF, 1'b1, 1'b0); step();
        check("R5 strobe ignored", rd_data, exp_view(9'h1AA, 1'b0, 1'b0, 1'b0, 1'b0));
        mode_sel = 3'b010;
        recv(9'h011, 1'b1, 1'b0); step();
        check("R5 re-enabled", rd_data, exp_view(9'h011, 1'b1, 1'b0, 1'b0, 1'b0));
        rx_enable = 1'b0; step();
        check("R5 enable low clears", rd_data, exp_view(9'h011, 1'b0, 1'b0, 1'b0, 1'b0));
        rx_enable = 1'b1; step();

        // R8: read in same cycle as new character, no overrun
        recv(9'h020, 1'b0, 1'b0); step();
        recv(9'h021, 1'b0, 1'b0); rd_lo = 1'b1; step();
        check("R8 read same cycle", rd_data, exp_view(9'h021, 1'b0, 1'b0, 1'b0, 1'b0));
        rd_lo = 1'b1; step();

        // R9: new parity wins over read, framing cleared by read
        recv(9'h030, 1'b0, 1'b1); step();
        check("R9 frm set", rd_data, exp_view(9'h030, 1'b0, 1'b1, 1'b0, 1'b0));
        recv(9'h031, 1'b1, 1'b0); rd_lo = 1'b1; step();
        check("R9 set beats read", rd_data, exp_view(9'h031, 1'b1, 1'b0, 1'b0, 1'b0));
        rd_lo = 1'b1; step();
        check("R4 final read", rd_data, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b0));

        // R6 R7 arbitration flag
        arb_lost = 1'b1; step();
        check("R6 arb set", rd_data, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b1));
        check("R7 noarb bit11", {15'h0, rd_data_n[11]}, 16'h0000);
        wr_en = 1'b1; wr_arb_val = 1'b1; step();
        check("R6 write one no effect", rd_data, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b1));
        rd_lo = 1'b1; step();
        check("R4 read keeps arb", rd_data, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b1));
        mode_sel = 3'b000; step();
        check("R5 disable keeps arb", rd_data, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b1));
        mode_sel = 3'b001;
        wr_en = 1'b1; wr_arb_val = 1'b0; step();
        check("R6 write zero clears", rd_data, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b0));
        arb_lost = 1'b1; wr_en = 1'b1; wr_arb_val = 1'b0; step();
        check("R9 arb set beats clear", rd_data, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b1));
        check("R7 noarb view", rd_data_n, exp_view(9'h031, 1'b0, 1'b0, 1'b0, 1'b0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule